// File: doc/BRIEF.md
# Program Counter Sequencer

This block holds the instruction address register of a simple 32-bit fetch stage and chooses its value for the next cycle. On every clock edge the address moves forward by one instruction (4 bytes), unless the decode and compare logic asks for a control transfer. Three kinds of transfer are supported:

- a conditional relative branch, whose target is the incremented address plus a signed word offset;
- an absolute jump, whose target is a 26-bit word index placed under the top bits of the incremented address;
- a jump through a register, whose target is a 32-bit value taken from the register file.

The incremented address is also given out in the same cycle as a link value. A call instruction writes this value to its return register.

Decode drives the select inputs and the instruction fields. The compare unit drives the branch-taken input. The instruction memory reads the current address output. The block does not handle delay slots, exception vectors or the memory itself.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` takes the parameter `BOOT_ADDR` (default 0) on that edge, whatever the other inputs are.
- R2: When no select input is high, `pc_q` advances by 4 at each edge.
- R3: When `take_branch` is high and neither jump select is high, the next `pc_q` is `pc_q + 4 + 4*signed(branch_off)`. This must hold at both ends of the offset range, 0x7FFF and 0x8000.
- R4: When `sel_jump` is high and `sel_jreg` is low, the next `pc_q` is formed as follows: bits [27:2] take `jump_field`, bits [1:0] are 0, and bits [31:28] are copied from the incremented address.
- R5: When `sel_jreg` is high, the next `pc_q` is `reg_value` with its two lowest bits forced to 0.
- R6: The selects are applied in a fixed priority order: `sel_jreg` first, then `sel_jump`, then `take_branch`, then the sequential step. A select of lower rank has no effect while one of higher rank is high.
- R7: `link_addr` always equals `pc_q + 4`, in the same cycle, modulo 2^32.
- R8: Bits [1:0] of `pc_q` are 0 in every cycle after reset.
- R9: The top four bits of a jump target come from `pc_q + 4`, not from `pc_q`. When `pc_q` is the last word of a 256 MB region, the jump therefore lands in the next region.
- R10: Address arithmetic wraps modulo 2^32. The step after 0xFFFFFFFC is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| branch_off | input | 16 | Signed branch offset, counted in instructions |
| jump_field | input | 26 | Word index of the absolute jump target |
| take_branch | input | 1 | Branch condition is met |
| sel_jump | input | 1 | Select the absolute jump |
| sel_jreg | input | 1 | Select the jump through a register |
| reg_value | input | 32 | Register value for the jump through a register |
| pc_q | output | 32 | Current instruction address |
| link_addr | output | 32 | Incremented address, used as the return value |

## Verification
The properties assume that the select inputs are stable around the clock edge. They also assume that `BOOT_ADDR` is word aligned, because the alignment property relies on reset landing on a multiple of 4. Select combinations that are illegal for decode are not excluded by the properties. The priority order defines the result for every combination, and the stimulus drives such mixes on purpose. It also drives a misaligned register value, so that the forced-zero low bits are observed at the output.

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int TGT_W  = 26,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFF_W-1:0]  branch_off,
  input  logic [TGT_W-1:0]  jump_field,
  input  logic              take_branch,
  input  logic              sel_jump,
  input  logic              sel_jreg,
  input  logic [ADDR_W-1:0] reg_value,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] link_addr
);
  localparam int HI_W  = ADDR_W - TGT_W - 2;
  localparam int EXT_W = ADDR_W - OFF_W - 2;

  logic [ADDR_W-1:0] inc, br_tgt, jmp_tgt, jr_tgt, nxt;

  assign inc     = pc_q + ADDR_W'(4);
  assign br_tgt  = inc + {{EXT_W{branch_off[OFF_W-1]}}, branch_off, 2'b00};
  assign jmp_tgt = {inc[ADDR_W-1 -: HI_W], jump_field, 2'b00};
  assign jr_tgt  = {reg_value[ADDR_W-1:2], 2'b00};

  always_comb begin
    if (sel_jreg)         nxt = jr_tgt;
    else if (sel_jump)    nxt = jmp_tgt;
    else if (take_branch) nxt = br_tgt;
    else                  nxt = inc;
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= BOOT_ADDR;
    else     pc_q <= nxt;
  end

  assign link_addr = inc;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int TGT_W  = 26
) (
  input logic              clk,
  input logic              rst,
  input logic [OFF_W-1:0]  branch_off,
  input logic [TGT_W-1:0]  jump_field,
  input logic              take_branch,
  input logic              sel_jump,
  input logic              sel_jreg,
  input logic [ADDR_W-1:0] reg_value,
  input logic [ADDR_W-1:0] pc_q
);
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!sel_jreg && !sel_jump && !take_branch) |=> pc_q == $past(pc_q) + ADDR_W'(4)); // R2

  AST_BRANCH_TGT: assert property (@(posedge clk) disable iff (rst)
    (!sel_jreg && !sel_jump && take_branch) |=>
      pc_q == $past(pc_q) + ADDR_W'(4)
              + ADDR_W'($signed($past(branch_off)) * 4)); // R3

  AST_JUMP_TGT: assert property (@(posedge clk) disable iff (rst)
    (!sel_jreg && sel_jump) |=>
      pc_q[TGT_W+1:0] == {$past(jump_field), 2'b00}); // R4

  AST_JREG_TGT: assert property (@(posedge clk) disable iff (rst)
    sel_jreg |=> pc_q[ADDR_W-1:2] == $past(reg_value[ADDR_W-1:2])); // R5

  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00); // R8
endmodule

bind pc_sequencer pc_sequencer_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TGT_W(TGT_W)
) u_chk (
  .clk(clk), .rst(rst), .branch_off(branch_off), .jump_field(jump_field),
  .take_branch(take_branch), .sel_jump(sel_jump), .sel_jreg(sel_jreg),
  .reg_value(reg_value), .pc_q(pc_q)
);

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] branch_off = '0;
  logic [25:0] jump_field = '0;
  logic        take_branch = 1'b0, sel_jump = 1'b0, sel_jreg = 1'b0;
  logic [31:0] reg_value = '0;
  logic [31:0] pc_q, link_addr;

  int checks = 0, errors = 0;
  logic [31:0] model_pc;

  always #5 clk = ~clk;

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rst(rst), .branch_off(branch_off), .jump_field(jump_field),
    .take_branch(take_branch), .sel_jump(sel_jump), .sel_jreg(sel_jreg),
    .reg_value(reg_value), .pc_q(pc_q), .link_addr(link_addr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(string req, logic br, logic jp, logic jr,
                      logic [15:0] off, logic [25:0] fld, logic [31:0] rv);
    logic [31:0] inc, exp;
    take_branch = br; sel_jump = jp; sel_jreg = jr;
    branch_off = off; jump_field = fld; reg_value = rv;
    inc = model_pc + 32'd4;
    #1 check("R7 link", link_addr, inc);
    if (jr)      exp = rv & ~32'h3;
    else if (jp) exp = (inc & 32'hF000_0000) | (32'(fld) * 4);
    else if (br) exp = inc + 32'($signed(off) * 4);
    else         exp = inc;
    @(posedge clk); #1;
    model_pc = exp;
    check(req, pc_q, exp);
    check("R8 align", {30'd0, pc_q[1:0]}, 32'd0);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    sel_jump = 1'b1; jump_field = 26'h155;
    repeat (2) @(posedge clk); #1;
    check("R1 reset", pc_q, 32'h0);
    rst = 1'b0; sel_jump = 1'b0;
    model_pc = 32'h0;
    step("R2 seq", 0, 0, 0, 16'h0, 26'h0, 32'h0);
    step("R2 seq", 0, 0, 0, 16'h1234, 26'h0, 32'h0);
    step("R3 branch fwd", 1, 0, 0, 16'd5, 26'h0, 32'h0);
    step("R3 branch back", 1, 0, 0, 16'hFFFD, 26'h0, 32'h0);
    step("R3 branch max", 1, 0, 0, 16'h7FFF, 26'h0, 32'h0);
    step("R3 branch min", 1, 0, 0, 16'h8000, 26'h0, 32'h0);
    step("R4 jump", 0, 1, 0, 16'h0, 26'h2AA_AAAA, 32'h0);
    step("R5 jreg misaligned", 0, 0, 1, 16'h0, 26'h0, 32'h0FFF_FFFF);
    step("R9 region carry", 0, 1, 0, 16'h0, 26'd5, 32'h0);
    step("R6 jreg over all", 1, 1, 1, 16'd7, 26'h3, 32'h4000_0010);
    step("R6 jump over branch", 1, 1, 0, 16'd7, 26'h40, 32'h0);
    step("R5 jreg top", 0, 0, 1, 16'h0, 26'h0, 32'hFFFF_FFFE);
    step("R10 wrap", 0, 0, 0, 16'h0, 26'h0, 32'h0);
    step("R2 seq", 0, 0, 0, 16'h0, 26'h0, 32'h0);
    step("R3 branch wrap", 1, 0, 0, 16'hFFFC, 26'h0, 32'h0);
    rst = 1'b1; take_branch = 1'b1; branch_off = 16'd9;
    @(posedge clk); #1;
    check("R1 reset midrun", pc_q, 32'h0);
    rst = 1'b0; take_branch = 1'b0;
    model_pc = 32'h0;
    step("R2 seq after reset", 0, 0, 0, 16'h0, 26'h0, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule